// File: doc/BRIEF.md
# Multi-Lane Deskew Release Buffer

This block is the receive-side alignment stage of a multi-lane serial link with deterministic latency. Every lane delivers already-decoded characters, each with a valid flag and a flag that marks the start of a multiframe. Each lane writes into its own elastic FIFO. A lane writes nothing until its first multiframe-start word arrives, and that word becomes the head of the FIFO.

A release controller watches a one-cycle pulse that marks the local multiframe clock boundary. It opens one release opportunity per multiframe, at a programmable number of cycles after the boundary. The FIFOs are released only at such an opportunity, and only once every enabled lane has buffered its first multiframe-start word. If a lane is late, the release waits a whole multiframe for the next opportunity. The total delay can therefore be longer than one multiframe.

After release, every enabled lane hands out one word per clock in lockstep until the next reset. The reset is the link reset. It flushes every FIFO and re-arms the controller.

Top module: `deskew_release_top`

## Requirements
- R1: The cycle in which `lmfcPulse` is sampled high has phase 0, and each later cycle adds one to the phase until the next pulse. The release is taken in the first cycle whose phase equals `relOffset` and in which every enabled lane has already arrived. The first aligned word (`alignedValid` high) appears one clock after that cycle. There is no release before the first `lmfcPulse` after reset.
- R2: A lane counts as arrived from the clock after its first multiframe-start word is written. If an enabled lane's start word is written in the release cycle itself or later, the release moves to the same offset in a following multiframe, even when that is more than one multiframe after the earliest lane.
- R3: With `relOffset` equal to 0, the release is taken in the very cycle in which `lmfcPulse` is high.
- R4: Words a lane receives before its first multiframe-start word are discarded. The first aligned word of every enabled lane is that lane's multiframe-start word. A start flag received after arrival is stored as ordinary data.
- R5: Once `alignedValid` rises, it stays high until reset. Every enabled lane then advances by exactly one word per clock, in arrival order. Lane k occupies bits [k*DATA_W +: DATA_W] of `alignedData`.
- R6: Lanes cleared in `laneEnable` (bit k controls lane k) take no part in the arrival check, store nothing, and drive zero on their slice of `alignedData`. At least one lane must be enabled before a release can happen.
- R7: Each lane FIFO holds FIFO_DEPTH words (default 2*MF_WORDS = 16). A word that arrives at a full FIFO with no read in the same cycle is dropped, and `overflowErr` goes high on the next clock and stays high until reset.
- R8: An asserted `rst_n` immediately clears `alignedValid`, `alignedData` and `overflowErr` and empties every FIFO. After reset the controller releases again by the rules of R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous link reset |
| laneData | input | LANES*DATA_W | Received characters, lane k in slice k |
| laneValid | input | LANES | Per-lane word valid |
| laneSomf | input | LANES | Per-lane multiframe-start marker, qualified by valid |
| lmfcPulse | input | 1 | One-cycle local multiframe boundary pulse |
| relOffset | input | OFFSET_W | Release point in cycles after the boundary |
| laneEnable | input | LANES | Lane participation mask |
| alignedData | output | LANES*DATA_W | Deskewed lane words |
| alignedValid | output | 1 | High from the first aligned word onward |
| overflowErr | output | 1 | Sticky FIFO overflow flag |

## Verification
The in-RTL checks rely on a few input rules. Once a lane's multiframe-start word has arrived, the lane keeps `laneValid` high every cycle, so a released FIFO never runs dry. `laneEnable` and `relOffset` stay constant between resets. `relOffset` is below the multiframe length, and `lmfcPulse` repeats every MF_WORDS cycles. The bench follows these rules: it drives every lane valid on every cycle, changes the mask and the offset only while the block is in reset, and generates the boundary pulse from a cycle counter modulo 8. Its lane skews are chosen so that no lane holds more than the FIFO depth before the release, except in the case that is meant to overflow.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

  // Strobes from the release controller to the lane datapath.
  typedef struct packed {
    logic releaseHit;  // release taken this cycle
    logic popEn;       // lanes drain one word per clock
  } relStrobe_t;

endpackage

// File: rtl/deskew_lane_fifo.sv
module deskew_lane_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16   // power of two
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              laneOn,
  input  logic              inValid,
  input  logic              inSomf,
  input  logic [DATA_W-1:0] inData,
  input  logic              popEn,
  output logic [DATA_W-1:0] headData,
  output logic              arrived,
  output logic              overflowPulse
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW:0] wrPtr, rdPtr, fillLevel;
  logic isEmpty, isFull, acceptWr, doWr, doRd;

  assign fillLevel = wrPtr - rdPtr;
  assign isEmpty   = (fillLevel == '0);
  assign isFull    = (fillLevel == (AW+1)'(DEPTH));

  // Words before the first multiframe start are discarded.
  assign acceptWr = laneOn && inValid && (arrived || inSomf);
  assign doRd     = popEn && laneOn && !isEmpty;
  assign doWr     = acceptWr && (!isFull || doRd);
  assign overflowPulse = acceptWr && isFull && !doRd;

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr[AW-1:0]] <= inData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      arrived <= 1'b0;
    end else begin
      if (doWr) wrPtr <= wrPtr + 1'b1;
      if (doRd) rdPtr <= rdPtr + 1'b1;
      if (doWr && inSomf) arrived <= 1'b1;
    end
  end

  assign headData = mem[rdPtr[AW-1:0]];

  // R4: a lane only becomes arrived through a valid start word.
  assert_arrive_on_somf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arrived) |-> $past(inValid && inSomf && laneOn));

  // R2: arrival is held until reset.
  assert_arrived_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arrived |=> arrived);

  // R5: input rule - a released lane never runs dry.
  assert_no_underrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (popEn && laneOn) |-> !isEmpty);
endmodule

// File: rtl/deskew_datapath.sv
module deskew_datapath
  import deskew_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*DATA_W-1:0] laneData,
  input  logic [LANES-1:0]        laneValid,
  input  logic [LANES-1:0]        laneSomf,
  input  logic [LANES-1:0]        laneEnable,
  input  relStrobe_t              strobes,
  output logic [LANES-1:0]        laneArrived,
  output logic [LANES*DATA_W-1:0] alignedData,
  output logic                    alignedValid,
  output logic                    overflowErr
);
  logic [LANES-1:0] ovfVec;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [DATA_W-1:0] headWord;
    logic [DATA_W-1:0] outReg;

    deskew_lane_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk          (clk),
      .rst_n        (rst_n),
      .laneOn       (laneEnable[k]),
      .inValid      (laneValid[k]),
      .inSomf       (laneSomf[k]),
      .inData       (laneData[k*DATA_W +: DATA_W]),
      .popEn        (strobes.popEn),
      .headData     (headWord),
      .arrived      (laneArrived[k]),
      .overflowPulse(ovfVec[k])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        outReg <= '0;
      else if (strobes.popEn)
        outReg <= laneEnable[k] ? headWord : '0;
    end

    assign alignedData[k*DATA_W +: DATA_W] = outReg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alignedValid <= 1'b0;
      overflowErr  <= 1'b0;
    end else begin
      if (strobes.popEn) alignedValid <= 1'b1;
      if (|ovfVec)       overflowErr  <= 1'b1;
    end
  end

  // R2: every enabled lane has arrived when the release is taken.
  assert_hit_all_arrived_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.releaseHit |-> &(laneArrived | ~laneEnable));

  // R7: the overflow flag is sticky.
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflowErr |=> overflowErr);

  // R5: aligned output stays valid once started.
  assert_valid_lockstep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alignedValid |=> alignedValid);
endmodule

// File: rtl/deskew_release_ctrl.sv
module deskew_release_ctrl
  import deskew_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int OFFSET_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lmfcPulse,
  input  logic [OFFSET_W-1:0] relOffset,
  input  logic [LANES-1:0]    laneEnable,
  input  logic [LANES-1:0]    laneArrived,
  output relStrobe_t          strobes
);
  // One spare bit so the idle phase can never equal an offset.
  localparam int PW = OFFSET_W + 1;
  localparam logic [PW-1:0] PH_IDLE = '1;

  logic [PW-1:0] phaseReg, phaseNow;
  logic released, allIn, hit;

  assign phaseNow = lmfcPulse ? '0 : phaseReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phaseReg <= PH_IDLE;
    else if (lmfcPulse)
      phaseReg <= PW'(1);
    else if (phaseReg != PH_IDLE)
      phaseReg <= phaseReg + 1'b1;
  end

  assign allIn = (&(laneArrived | ~laneEnable)) && (|laneEnable);
  assign hit   = !released && allIn && (phaseNow == {1'b0, relOffset});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   released <= 1'b0;
    else if (hit) released <= 1'b1;
  end

  assign strobes.releaseHit = hit;
  assign strobes.popEn      = released;

  // R3: a zero offset releases on the boundary cycle itself.
  assert_offset_zero_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && relOffset == '0) |-> lmfcPulse);

  // R1: an offset of one releases the cycle after a boundary.
  assert_offset_one_after_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && relOffset == OFFSET_W'(1)) |-> $past(lmfcPulse));

  // R1: a release is taken only once per reset.
  assert_release_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    released |=> (released && !hit));
endmodule

// File: rtl/deskew_release_top.sv
module deskew_release_top
  import deskew_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int DATA_W     = 8,
  parameter int MF_WORDS   = 8,
  parameter int FIFO_DEPTH = 2 * MF_WORDS,
  parameter int OFFSET_W   = $clog2(MF_WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*DATA_W-1:0] laneData,
  input  logic [LANES-1:0]        laneValid,
  input  logic [LANES-1:0]        laneSomf,
  input  logic                    lmfcPulse,
  input  logic [OFFSET_W-1:0]     relOffset,
  input  logic [LANES-1:0]        laneEnable,
  output logic [LANES*DATA_W-1:0] alignedData,
  output logic                    alignedValid,
  output logic                    overflowErr
);
  relStrobe_t       strobes;
  logic [LANES-1:0] laneArrived;

  deskew_release_ctrl #(.LANES(LANES), .OFFSET_W(OFFSET_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lmfcPulse  (lmfcPulse),
    .relOffset  (relOffset),
    .laneEnable (laneEnable),
    .laneArrived(laneArrived),
    .strobes    (strobes)
  );

  deskew_datapath #(.LANES(LANES), .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .laneData    (laneData),
    .laneValid   (laneValid),
    .laneSomf    (laneSomf),
    .laneEnable  (laneEnable),
    .strobes     (strobes),
    .laneArrived (laneArrived),
    .alignedData (alignedData),
    .alignedValid(alignedValid),
    .overflowErr (overflowErr)
  );
endmodule

// File: tb/deskew_release_top_tb.sv
module deskew_release_top_tb;
  localparam int LANES = 4;
  localparam int DW    = 8;
  localparam int MF    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES*DW-1:0] laneData = '0;
  logic [LANES-1:0]    laneValid = '0;
  logic [LANES-1:0]    laneSomf = '0;
  logic                lmfcPulse = 1'b0;
  logic [2:0]          relOffset = '0;
  logic [LANES-1:0]    laneEnable = '0;
  logic [LANES*DW-1:0] alignedData;
  logic                alignedValid;
  logic                overflowErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5ns clk = ~clk;

  deskew_release_top u_dut (
    .clk(clk), .rst_n(rst_n), .laneData(laneData), .laneValid(laneValid),
    .laneSomf(laneSomf), .lmfcPulse(lmfcPulse), .relOffset(relOffset),
    .laneEnable(laneEnable), .alignedData(alignedData),
    .alignedValid(alignedValid), .overflowErr(overflowErr)
  );

  // somf[k]: cycle of lane k's start word (63 = never); ph: boundary phase (8 = none)
  typedef struct packed {
    logic [3:0][5:0] somf;
    logic [3:0]      mask;
    logic [2:0]      off;
    logic [3:0]      ph;
    logic [7:0]      expR;   // edge at which the release is taken
  } vecRow_t;

  // somf packed lane3..lane0
  localparam vecRow_t VEC_TABLE [8] = '{
    '{{6'd5,  6'd4,  6'd3, 6'd2},  4'hF, 3'd3, 4'd0, 8'd11},  // R1 skewed lanes
    '{{6'd1,  6'd1,  6'd1, 6'd1},  4'hF, 3'd0, 4'd4, 8'd4},   // R3 zero offset
    '{{6'd3,  6'd2,  6'd9, 6'd1},  4'hF, 3'd2, 4'd0, 8'd10},  // R2 late lane, >1 multiframe
    '{{6'd5,  6'd0,  6'd0, 6'd0},  4'hF, 3'd5, 4'd0, 8'd13},  // R2 arrives in release cycle
    '{{6'd4,  6'd0,  6'd0, 6'd0},  4'hF, 3'd5, 4'd0, 8'd5},   // R2 arrives one cycle earlier
    '{{6'd63, 6'd2,  6'd63, 6'd3}, 4'h5, 3'd1, 4'd2, 8'd11},  // R6 masked lanes
    '{{6'd6,  6'd63, 6'd63, 6'd63},4'h8, 3'd7, 4'd1, 8'd8},   // R6 single lane
    '{{6'd7,  6'd7,  6'd7, 6'd7},  4'hF, 3'd0, 4'd7, 8'd15}   // R3/R2 zero offset missed
  };

  task automatic report(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic resetDut();
    rst_n = 1'b0;
    laneValid = '0; laneSomf = '0; laneData = '0; lmfcPulse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drives nCyc cycles and checks after every edge.
  task automatic driveRun(input vecRow_t v, input int nCyc, input int expR,
                          input int ovfEdge, input string tag);
    relOffset  = v.off;
    laneEnable = v.mask;
    for (int c = 0; c < nCyc; c++) begin
      logic [LANES*DW-1:0] expData;
      bit expValid, expOvf;
      lmfcPulse = (v.ph < 8) && ((c % MF) == int'(v.ph));
      for (int k = 0; k < LANES; k++) begin
        int s;
        s = int'(v.somf[k]);
        laneValid[k] = 1'b1;
        laneSomf[k]  = (c == s);
        laneData[k*DW +: DW] = (c >= s) ? {2'(k), 6'(c - s)} : {2'(k), 6'h3F};
      end
      @(negedge clk);
      expValid = (expR >= 0) && (c >= expR + 1);
      expOvf   = (ovfEdge >= 0) && (c >= ovfEdge);
      expData  = '0;
      for (int k = 0; k < LANES; k++)
        if (expValid && v.mask[k]) expData[k*DW +: DW] = {2'(k), 6'(c - expR - 1)};
      report(alignedValid == expValid, tag, "alignedValid (R1/R5)",
             64'(alignedValid), 64'(expValid));
      report(alignedData == expData, tag, "alignedData (R4/R5/R6)",
             64'(alignedData), 64'(expData));
      report(overflowErr == expOvf, tag, "overflowErr (R7)",
             64'(overflowErr), 64'(expOvf));
    end
  endtask

  initial begin
    #1ms;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    vecRow_t d;
    resetDut();
    // R8: reset state
    report(alignedValid == 1'b0, "R8", "reset alignedValid", 64'(alignedValid), 64'd0);
    report(alignedData == '0, "R8", "reset alignedData", 64'(alignedData), 64'd0);
    report(overflowErr == 1'b0, "R8", "reset overflowErr", 64'(overflowErr), 64'd0);

    // Vector table: R1..R6 release timing and lane contents
    for (int i = 0; i < 8; i++) begin
      string tag;
      case (i)
        1, 7:    tag = "R3";
        2, 3, 4: tag = "R2";
        5, 6:    tag = "R6";
        default: tag = "R1";
      endcase
      resetDut();
      driveRun(VEC_TABLE[i], int'(VEC_TABLE[i].expR) + 8,
               int'(VEC_TABLE[i].expR), -1, tag);
    end

    // R8: asynchronous reset while released clears outputs at once
    rst_n = 1'b0;
    #1ns;
    report(alignedValid == 1'b0, "R8", "reset after release alignedValid",
           64'(alignedValid), 64'd0);
    report(alignedData == '0, "R8", "reset after release alignedData",
           64'(alignedData), 64'd0);

    // R1: all lanes arrived but no boundary pulse - no release
    resetDut();
    d = '{somf: {6'd1, 6'd1, 6'd1, 6'd1}, mask: 4'hF, off: 3'd2, ph: 4'd8, expR: 8'd0};
    driveRun(d, 12, -1, -1, "R1");

    // R7: lane 1 never arrives, lane 0 fills 16 words, overflow on edge 16
    resetDut();
    d = '{somf: {6'd63, 6'd63, 6'd63, 6'd0}, mask: 4'h3, off: 3'd0, ph: 4'd0, expR: 8'd0};
    driveRun(d, 26, -1, 16, "R7");

    // R8: reset clears the sticky flag, then the controller re-arms
    resetDut();
    report(overflowErr == 1'b0, "R8", "overflowErr after reset", 64'(overflowErr), 64'd0);
    driveRun(VEC_TABLE[0], 19, 11, -1, "R8");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule